// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned operands and produces the full-width product. It accepts one new operand pair on every clock and returns one product on every clock. The usual shift-and-add loop has been laid out in space. There is one adder stage for each bit of the multiplier operand, and a register follows each stage. An operation therefore moves one stage forward per cycle, and many operations are in flight at once.

Stage k adds the multiplicand, shifted left by k, to the running partial sum when multiplier bit k is set. Each multiplier bit waits in its own delay line of k flops, so it reaches stage k in the same cycle as its operation. The multiplicand does not use a delay line. It is registered in every stage and travels with the partial sum. A valid flag travels with each operation and marks which outputs are live. The pipeline has no stall input. A consumer must take a product in the cycle it appears.

Top module: `pmul_array`

## Requirements
- R1: With `out_vld` high, `product` equals the unsigned product `mcand * mplier` of the pair that was accepted with it.
- R2: A pair presented with `in_vld` high in cycle n yields `out_vld` high in cycle n+8, exactly 8 cycles later for the default 8-bit multiplier.
- R3: Pairs accepted in consecutive cycles yield products in consecutive cycles, in the same order, with no gap.
- R4: A zero in either operand yields a product of 0x0000.
- R5: The product is 16 bits wide with nothing dropped: 0xFF times 0xFF yields 0xFE01.
- R6: Reset clears every valid flag. `out_vld` is low while reset is held. An operation already in the pipeline when reset is applied never produces a valid output, and an operation accepted in the same cycle as reset also produces none.
- R7: A cycle with `in_vld` low produces a cycle with `out_vld` low 8 cycles later, whatever the operand values were.
- R8: A multiplier that is a single power of two, 2^k, yields the multiplicand shifted left by k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid flags |
| in_vld | input | 1 | Operand pair on `mcand`/`mplier` is live this cycle |
| mcand | input | A_W (8) | Multiplicand, unsigned |
| mplier | input | B_W (8) | Multiplier, unsigned |
| out_vld | output | 1 | `product` is live this cycle |
| product | output | A_W+B_W (16) | Unsigned product, registered |

## Verification
Every result of this block is due a fixed 8 cycles after its operands are sampled. Both the validity flag and the product value follow that one rule. The bench logs its inputs and a reset flag in a record indexed by cycle. In each cycle it compares the outputs with the record from 8 cycles earlier. A record is expected to be invalid if its input was idle, or if reset was applied in any of the 8 cycles during which that operation was in flight. The bound checker keeps the same 8-deep history from its own shift registers and compares `out_vld` and `product` with it on every edge.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  // Default operand widths for the array multiplier.
  localparam int unsigned PM_A_W = 8;
  localparam int unsigned PM_B_W = 8;
endpackage

// File: rtl/pmul_bit_delay.sv
// Delay line of DEPTH flops for one multiplier bit (DEPTH >= 1).
module pmul_bit_delay #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    sr <= (sr << 1) | DEPTH'(d);
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/pmul_stage.sv
// One unrolled accumulation step: conditionally add the multiplicand,
// shifted left by SHIFT, to the partial sum, then register.
module pmul_stage #(
  parameter int unsigned A_W   = 8,
  parameter int unsigned P_W   = 16,
  parameter int unsigned SHIFT = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_i,
  input  logic [A_W-1:0] a_i,
  input  logic           bit_i,
  input  logic [P_W-1:0] acc_i,
  output logic           v_o,
  output logic [A_W-1:0] a_o,
  output logic [P_W-1:0] acc_o
);
  localparam int unsigned EXT = P_W - A_W;

  logic [P_W-1:0] addend;

  always_comb begin
    addend = {{EXT{1'b0}}, a_i} << SHIFT;
  end

  // Only the valid flag is reset; data registers are free-running.
  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    a_o   <= a_i;
    acc_o <= bit_i ? (acc_i + addend) : acc_i;
  end
endmodule

// File: rtl/pmul_array.sv
module pmul_array
  import pmul_pkg::*;
#(
  parameter int unsigned A_W = PM_A_W,
  parameter int unsigned B_W = PM_B_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [A_W-1:0]       mcand,
  input  logic [B_W-1:0]       mplier,
  output logic                 out_vld,
  output logic [A_W+B_W-1:0]   product
);
  localparam int unsigned P_W = A_W + B_W;

  // Index 0 is the block input; index k+1 is the output of stage k.
  logic           s_v   [0:B_W];
  logic [A_W-1:0] s_a   [0:B_W];
  logic [P_W-1:0] s_acc [0:B_W];
  logic [B_W-1:0] bit_at_stage;

  assign s_v[0]   = in_vld;
  assign s_a[0]   = mcand;
  assign s_acc[0] = '0;

  for (genvar k = 0; k < B_W; k++) begin : g_stage
    if (k == 0) begin : g_nodly
      assign bit_at_stage[k] = mplier[k];
    end else begin : g_dly
      pmul_bit_delay #(.DEPTH(k)) u_dly (
        .clk (clk),
        .d   (mplier[k]),
        .q   (bit_at_stage[k])
      );
    end

    pmul_stage #(.A_W(A_W), .P_W(P_W), .SHIFT(k)) u_stg (
      .clk   (clk),
      .rst   (rst),
      .v_i   (s_v[k]),
      .a_i   (s_a[k]),
      .bit_i (bit_at_stage[k]),
      .acc_i (s_acc[k]),
      .v_o   (s_v[k+1]),
      .a_o   (s_a[k+1]),
      .acc_o (s_acc[k+1])
    );
  end

  assign out_vld = s_v[B_W];
  assign product = s_acc[B_W];
endmodule

// File: rtl/pmul_array_chk.sv
module pmul_array_chk #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_vld,
  input logic [A_W-1:0]     mcand,
  input logic [B_W-1:0]     mplier,
  input logic               out_vld,
  input logic [A_W+B_W-1:0] product
);
  localparam int unsigned P_W = A_W + B_W;
  localparam logic [P_W-1:0] MAXP = P_W'((2**A_W - 1) * (2**B_W - 1));

  logic [B_W-1:0] hv;
  logic [B_W-1:0] hz;
  logic [B_W-1:0] hm;
  logic [P_W-1:0] hp [B_W];

  always_ff @(posedge clk) begin
    if (rst) hv <= '0;
    else     hv <= {hv[B_W-2:0], in_vld};
  end

  always_ff @(posedge clk) begin
    hz    <= {hz[B_W-2:0], (mcand == '0) || (mplier == '0)};
    hm    <= {hm[B_W-2:0], (&mcand) && (&mplier)};
    hp[0] <= P_W'(mcand) * P_W'(mplier);
    for (int i = 1; i < B_W; i++) hp[i] <= hp[i-1];
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_vld == hv[B_W-1]); // R2

  AST_PROD_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> product == hp[B_W-1]); // R1

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (out_vld && hz[B_W-1]) |-> product == '0); // R4

  AST_FULL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (out_vld && hm[B_W-1]) |-> product == MAXP); // R5

  AST_POST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_vld); // R6
endmodule

bind pmul_array pmul_array_chk #(.A_W(A_W), .B_W(B_W)) u_chk (.*);

// File: tb/tb_pmul_array.sv
module tb_pmul_array;
  localparam int LAT = 8;
  localparam int NREC = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [7:0]  mcand = '0;
  logic [7:0]  mplier = '0;
  logic        out_vld;
  logic [15:0] product;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic        rec_v [0:NREC-1];
  logic        rec_r [0:NREC-1];
  logic [15:0] rec_p [0:NREC-1];
  string       rec_tag [0:NREC-1];

  // {mcand, mplier, expected product}
  localparam logic [31:0] VEC [12] = '{
    {8'h00, 8'h00, 16'h0000},
    {8'hFF, 8'hFF, 16'hFE01},
    {8'h01, 8'h01, 16'h0001},
    {8'h12, 8'h34, 16'h03A8},
    {8'hFF, 8'h00, 16'h0000},
    {8'h00, 8'hAB, 16'h0000},
    {8'h03, 8'h05, 16'h000F},
    {8'h80, 8'h80, 16'h4000},
    {8'hA5, 8'h01, 16'h00A5},
    {8'h01, 8'h80, 16'h0080},
    {8'h0F, 8'hF0, 16'h0E10},
    {8'hAA, 8'h55, 16'h3872}
  };

  pmul_array dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .mcand(mcand), .mplier(mplier),
    .out_vld(out_vld), .product(product)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic drive(input logic r, input logic v, input logic [7:0] a,
                       input logic [7:0] b, input logic [15:0] p, input string tag);
    @(negedge clk);
    rst = r; in_vld = v; mcand = a; mplier = b;
    rec_r[cyc] = r; rec_v[cyc] = v; rec_p[cyc] = p; rec_tag[cyc] = tag;
  endtask

  // Monitor: outputs of cycle cyc belong to the inputs recorded LAT cycles earlier.
  always @(posedge clk) begin
    #2;
    if (!done && cyc >= LAT) begin
      int j;
      bit killed;
      j = cyc - LAT;
      killed = 1'b0;
      for (int i = j; i < cyc; i++) if (rec_r[i]) killed = 1'b1;
      tests++;
      if (rec_v[j] && !killed) begin
        if (!(out_vld === 1'b1 && product === rec_p[j])) begin
          fails++;
          $display("FAIL %s: vld=%b product=%h expected vld=1 product=%h (cycle %0d)",
                   rec_tag[j], out_vld, product, rec_p[j], cyc);
        end
      end else begin
        if (out_vld !== 1'b0) begin
          fails++;
          $display("FAIL %s: vld=%b expected vld=0 (cycle %0d)",
                   killed ? "R6" : "R7", out_vld, cyc);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREC; i++) begin
      rec_v[i] = 1'b0; rec_r[i] = 1'b0; rec_p[i] = '0; rec_tag[i] = "R7";
    end
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 8'h00, 8'h00, 16'h0, "R6");
    // R6: reset state, valid output low during reset
    @(posedge clk); #2;
    tests++;
    if (out_vld !== 1'b0) begin
      fails++;
      $display("FAIL R6: reset vld=%b expected 0", out_vld);
    end

    // Vector table, back-to-back: R1, R4, R5, R8
    for (int i = 0; i < 12; i++) begin
      logic [7:0] a, b;
      string t;
      a = VEC[i][31:24]; b = VEC[i][23:16];
      if (a == 0 || b == 0)             t = "R4";
      else if (a == 8'hFF && b == 8'hFF) t = "R5";
      else if ($countones(b) == 1)       t = "R8";
      else                               t = "R1";
      drive(1'b0, 1'b1, a, b, VEC[i][15:0], t);
    end
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, 8'h5A, 8'hC3, 16'h0, "R7");

    // R8: every single-bit multiplier
    for (int k = 0; k < 8; k++)
      drive(1'b0, 1'b1, 8'hB7, 8'(1 << k), 16'(16'hB7 << k), "R8");

    // R3: random operands every cycle
    for (int i = 0; i < 150; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      drive(1'b0, 1'b1, a, b, 16'(a) * 16'(b), "R3");
    end

    // R7 / R2: alternating live and idle cycles with junk operands
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      if (i % 2 == 0) drive(1'b0, 1'b1, a, b, 16'(a) * 16'(b), "R2");
      else            drive(1'b0, 1'b0, a, b, 16'h0, "R7");
    end

    // R6: reset while operations are in flight
    for (int i = 0; i < 5; i++)
      drive(1'b0, 1'b1, 8'(i + 3), 8'h11, 16'(i + 3) * 16'h11, "R6");
    drive(1'b1, 1'b1, 8'h77, 8'h77, 16'h0, "R6");
    for (int i = 0; i < 4; i++)
      drive(1'b0, 1'b1, 8'(i + 9), 8'h21, 16'(i + 9) * 16'h21, "R1");

    for (int i = 0; i < 12; i++) drive(1'b0, 1'b0, 8'h00, 8'h00, 16'h0, "R7");
    @(posedge clk); #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule